// File: doc/BRIEF.md
# Gated Dual-Mode Timer/Counter

This block is a 16-bit up-counter held as two byte registers, a low half and a high half. It can run in one of two layouts. In the wide layout the two halves form one 16-bit counter. In the reload layout only the low half counts, and the high half holds the value that the low half restarts from. Each increment comes from one of two sources: a machine-cycle tick made by dividing a free-running oscillator enable by `PRESCALE`, or a falling edge seen on an external event pin. A gate option also lets an external level pin hold the count. When the counter wraps, a sticky overflow flag is set. The interrupt controller clears the flag with an acknowledge pulse.

A processor sets up the block through a four-entry register window: low half, high half, a mode nibble, and a control byte that holds the run bit and the flag. It then starts the count and waits for the flag. Both external pins pass through synchronizers before they are used. The event pin is sampled once per machine tick, so the fastest event rate it can count is one event per two machine cycles.

Top module: `timer_counter`

## Requirements
- R1: After reset, all four registers read zero and `tf` is low.
- R2: In timer mode (C/T bit = 0) the count advances once for every `PRESCALE` cycles in which `tick_en` is high, and only while the run bit is set.
- R3: When the mode field M1M0 = 01, the two halves count as one value {TH,TL}. A step from 0xFFFF wraps the value to 0x0000 and sets TF.
- R4: When M1M0 = 10, only TL counts. A step from 0xFF loads TL with TH and sets TF. TH does not change.
- R5: M1M0 = 00 and M1M0 = 11 behave exactly like M1M0 = 01.
- R6: In counter mode (C/T bit = 1) the count advances once for each 1-to-0 change of `t_pin` between two consecutive machine-tick samples. A steady level adds nothing, even while machine ticks keep occurring.
- R7: With the GATE bit set, counting happens only while `int_pin` is high. With `int_pin` low, the counter holds its value.
- R8: With the run bit clear, TH and TL hold their values whatever `tick_en` and `t_pin` do.
- R9: A processor write to TL or TH in a cycle where an increment is due takes effect, and that increment is dropped.
- R10: TF is cleared by a one-cycle `tf_ack` pulse or by a write of 0 to control bit 1. An overflow in the same cycle as an acknowledge leaves TF set.
- R11: Register select values: 0 = TL, 1 = TH, 2 = mode, 3 = control. The mode register uses bits [3:0] = GATE, C/T, M1, M0 (MSB to LSB), and its upper bits read 0. The control register has bit 0 = run and bit 1 = TF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tick_en | input | 1 | Oscillator enable that feeds the machine-cycle divider |
| t_pin | input | 1 | External event pin (asynchronous) |
| int_pin | input | 1 | External gate level pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| wr_data | input | HALF_W | Write data |
| rd_data | output | HALF_W | Read data of the selected register (combinational) |
| tf_ack | input | 1 | Flag clear from the interrupt controller |
| tf | output | 1 | Overflow flag |

## Verification
The bench builds the block with `PRESCALE = 4` and the default byte width and synchronizer depth. With this divider, a machine tick happens every fourth enabled cycle. That makes it cheap to feed an exact number of ticks, to hit both wrap points, and to line up a processor write or an acknowledge with the one cycle in which an increment lands. The default byte width keeps the 0xFFFF and 0xFF wrap values the same as in the requirements. The two-stage synchronizer sets the settling wait the bench uses after moving `t_pin` or `int_pin`.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int SEL_W = 2;
  localparam int CFG_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_MODE = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // bit positions inside the mode nibble
  localparam int CFG_GATE = 3;
  localparam int CFG_SRC  = 2;
  localparam int CFG_M1   = 1;
  localparam int CFG_M0   = 0;

  // bit positions inside the control byte
  localparam int CTL_RUN = 0;
  localparam int CTL_TF  = 1;
endpackage

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
  parameter int PRESCALE = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic mc_tick
);
  localparam int PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] phase_q;

  assign mc_tick = tick_en && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else if (tick_en) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  generate
    if (PRESCALE > 1) begin : g_spacing
      p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mc_tick |=> !mc_tick);
    end
  endgenerate
endmodule

// File: rtl/tc_sync.sv
module tc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else sh_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              reload_mode,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              tf_wr,
  input  logic              tf_wval,
  input  logic              tf_ack,
  output logic [HALF_W-1:0] th,
  output logic [HALF_W-1:0] tl,
  output logic              tf
);
  localparam int FULL_W = 2 * HALF_W;

  logic cpu_wr;
  logic step;
  logic ovf;
  logic [FULL_W-1:0] wide_next;

  assign cpu_wr    = wr_lo || wr_hi;
  assign step      = inc && !cpu_wr;
  assign wide_next = {th, tl} + 1'b1;
  assign ovf       = step && (reload_mode ? (&tl) : (&{th, tl}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th <= '0;
      tl <= '0;
    end else if (cpu_wr) begin
      if (wr_lo) tl <= wr_data;
      if (wr_hi) th <= wr_data;
    end else if (step) begin
      if (reload_mode) tl <= (&tl) ? th : tl + 1'b1;
      else {th, tl} <= wide_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tf <= 1'b0;
    else if (ovf) tf <= 1'b1;
    else if (tf_wr) tf <= tf_wval;
    else if (tf_ack) tf <= 1'b0;
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !cpu_wr && !reload_mode && (&th) && (&tl)) |=> (tf && th == '0 && tl == '0));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !cpu_wr && reload_mode && (&tl)) |=> (tf && tl == $past(th) && $stable(th)));
  p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && wr_lo) |=> (tl == $past(wr_data)));
  p_tf_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && tf_ack) |=> tf);
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int HALF_W      = 8,
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              t_pin,
  input  logic              int_pin,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [HALF_W-1:0] wr_data,
  output logic [HALF_W-1:0] rd_data,
  input  logic              tf_ack,
  output logic              tf
);
  import tc_pkg::*;

  logic [CFG_W-1:0]  cfg_q;
  logic              run_q;
  logic              mc_tick;
  logic              t_s, int_s, t_prev_q;
  logic              t_fall, src_evt, gate_ok, inc;
  logic              wr_lo, wr_hi, wr_cfg, wr_ctl;
  logic              reload_mode;
  logic [HALF_W-1:0] th, tl;

  assign wr_lo  = wr_en && (reg_sel == SEL_LO);
  assign wr_hi  = wr_en && (reg_sel == SEL_HI);
  assign wr_cfg = wr_en && (reg_sel == SEL_MODE);
  assign wr_ctl = wr_en && (reg_sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= wr_data[CFG_W-1:0];
      if (wr_ctl) run_q <= wr_data[CTL_RUN];
    end
  end

  tc_prescaler #(.PRESCALE(PRESCALE)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mc_tick(mc_tick)
  );

  tc_sync #(.STAGES(SYNC_STAGES)) u_sync_t (
    .clk(clk), .rst_n(rst_n), .d(t_pin), .q(t_s)
  );

  tc_sync #(.STAGES(SYNC_STAGES)) u_sync_int (
    .clk(clk), .rst_n(rst_n), .d(int_pin), .q(int_s)
  );

  // event pin sampled once per machine tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_prev_q <= 1'b0;
    else if (mc_tick) t_prev_q <= t_s;
  end

  assign t_fall      = mc_tick && t_prev_q && !t_s;
  assign src_evt     = cfg_q[CFG_SRC] ? t_fall : mc_tick;
  assign gate_ok     = !cfg_q[CFG_GATE] || int_s;
  assign inc         = run_q && gate_ok && src_evt;
  assign reload_mode = cfg_q[CFG_M1] && !cfg_q[CFG_M0];

  tc_count_core #(.HALF_W(HALF_W)) u_core (
    .clk(clk), .rst_n(rst_n), .inc(inc), .reload_mode(reload_mode),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .tf_wr(wr_ctl), .tf_wval(wr_data[CTL_TF]), .tf_ack(tf_ack),
    .th(th), .tl(tl), .tf(tf)
  );

  always_comb begin
    rd_data = '0;
    case (reg_sel)
      SEL_LO:   rd_data = tl;
      SEL_HI:   rd_data = th;
      SEL_MODE: rd_data[CFG_W-1:0] = cfg_q;
      default: begin
        rd_data[CTL_RUN] = run_q;
        rd_data[CTL_TF]  = tf;
      end
    endcase
  end

  p_edge_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    t_fall |=> !t_fall);
  p_gate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CFG_GATE] && !int_s && !wr_lo && !wr_hi) |=> ($stable(tl) && $stable(th)));
  p_run_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_lo && !wr_hi) |=> ($stable(tl) && $stable(th)));
  p_read_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && reg_sel == SEL_MODE) |=> (reg_sel != SEL_MODE || rd_data[CFG_W-1:0] == $past(wr_data[CFG_W-1:0])));
endmodule

// File: tb/sim_timer_counter.sv
module sim_timer_counter;
  localparam int P = 4;
  localparam int NV = 8;
  // {mode, th, tl, ticks, exp_th, exp_tl, exp_tf}
  localparam logic [44:0] VEC [NV] = '{
    {4'h1, 8'h00, 8'h00, 8'd5, 8'h00, 8'h05, 1'b0},
    {4'h1, 8'h00, 8'hFE, 8'd3, 8'h01, 8'h01, 1'b0},
    {4'h1, 8'hFF, 8'hFD, 8'd4, 8'h00, 8'h01, 1'b1},
    {4'h2, 8'hF0, 8'hFC, 8'd5, 8'hF0, 8'hF1, 1'b1},
    {4'h2, 8'h00, 8'hFF, 8'd1, 8'h00, 8'h00, 1'b1},
    {4'h0, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'h00, 1'b1},
    {4'h3, 8'h12, 8'h34, 8'd2, 8'h12, 8'h36, 1'b0},
    {4'h2, 8'h80, 8'h7F, 8'd3, 8'h80, 8'h82, 1'b0}
  };

  logic clk = 0, rst_n = 0, tick_en = 0, t_pin = 1, int_pin = 0;
  logic wr_en = 0, tf_ack = 0, tf;
  logic [1:0] reg_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  int checks = 0, errors = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  timer_counter #(.HALF_W(8), .PRESCALE(P), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .t_pin(t_pin), .int_pin(int_pin),
    .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .tf_ack(tf_ack), .tf(tf)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1; reg_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; #1; d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
    end
    @(negedge clk); tick_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(input logic [3:0] m, input logic [7:0] h, input logic [7:0] l);
    wr(2'd3, 8'h00); wr(2'd2, {4'h0, m}); wr(2'd1, h); wr(2'd0, l); wr(2'd3, 8'h01);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1 TL", v, 8'h00);
    rd(2'd1, v); check("R1 TH", v, 8'h00);
    rd(2'd2, v); check("R1 mode", v, 8'h00);
    rd(2'd3, v); check("R1 ctrl", v, 8'h00);
    check("R1 tf", {7'b0, tf}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4 R5 vector walk
    for (int k = 0; k < NV; k++) begin
      setup(VEC[k][44:41], VEC[k][40:33], VEC[k][32:25]);
      ticks(int'(VEC[k][24:17]) * P);
      rd(2'd1, v); check($sformatf("R2/R3/R4/R5 vec%0d TH", k), v, VEC[k][16:9]);
      rd(2'd0, v); check($sformatf("R2/R3/R4/R5 vec%0d TL", k), v, VEC[k][8:1]);
      check($sformatf("R3/R4 vec%0d tf", k), {7'b0, tf}, {7'b0, VEC[k][0]});
    end

    // R11 mode readback
    wr(2'd2, 8'hFA);
    rd(2'd2, v); check("R11 mode read", v, 8'h0A);

    // R8 run clear holds count
    setup(4'h1, 8'h00, 8'h20);
    wr(2'd3, 8'h00);
    ticks(3 * P);
    rd(2'd0, v); check("R8 TL held", v, 8'h20);

    // R7 gate
    setup(4'h9, 8'h00, 8'h00);
    int_pin = 0; settle();
    ticks(3 * P);
    rd(2'd0, v); check("R7 gated low", v, 8'h00);
    int_pin = 1; settle();
    ticks(2 * P);
    rd(2'd0, v); check("R7 gate high", v, 8'h02);

    // R6 counter mode
    setup(4'h5, 8'h00, 8'h00);
    t_pin = 1; settle(); ticks(P);
    t_pin = 0; settle(); ticks(P);
    t_pin = 0; settle(); ticks(P);
    rd(2'd0, v); check("R6 one edge", v, 8'h01);
    t_pin = 1; settle(); ticks(P);
    t_pin = 0; settle(); ticks(P);
    rd(2'd0, v); check("R6 two edges", v, 8'h02);
    t_pin = 1;

    // R9 write wins over increment
    setup(4'h1, 8'h00, 8'h10);
    for (int i = 0; i < P - 1; i++) begin
      @(negedge clk); tick_en = 1;
    end
    @(negedge clk); tick_en = 1; wr_en = 1; reg_sel = 2'd0; wr_data = 8'h55;
    @(negedge clk); tick_en = 0; wr_en = 0;
    rd(2'd0, v); check("R9 TL written", v, 8'h55);
    rd(2'd1, v); check("R9 TH kept", v, 8'h00);
    ticks(P);
    rd(2'd0, v); check("R9 next tick", v, 8'h56);

    // R10 flag clear paths
    setup(4'h2, 8'h00, 8'hFF);
    ticks(P);
    check("R10 tf set", {7'b0, tf}, 8'h01);
    @(negedge clk); tf_ack = 1;
    @(negedge clk); tf_ack = 0;
    check("R10 ack clears", {7'b0, tf}, 8'h00);
    wr(2'd0, 8'hFF); ticks(P);
    wr(2'd3, 8'h01);
    check("R10 write clears", {7'b0, tf}, 8'h00);
    wr(2'd0, 8'hFF);
    for (int i = 0; i < P - 1; i++) begin
      @(negedge clk); tick_en = 1;
    end
    @(negedge clk); tick_en = 1; tf_ack = 1;
    @(negedge clk); tick_en = 0; tf_ack = 0;
    check("R10 ovf beats ack", {7'b0, tf}, 8'h01);
    rd(2'd3, v); check("R11 ctrl read", v, 8'h03);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule